// File: doc/BRIEF.md
# Byte-Lane Bus Access Sequencer

This block sits between a core that issues byte and 16-bit word memory requests on a 20-bit byte address and a memory port whose data path is 16 bits wide, split into a low lane (bits 7:0) and a high lane (bits 15:8). A byte whose address is even moves on the low lane and a byte whose address is odd moves on the high lane. An active-high enable per lane tells memory which lanes a bus cycle uses.

A word at an even address needs one bus cycle with both lanes enabled. A word at an odd address cannot be moved in one cycle. The sequencer splits it into two single-byte cycles. The byte at the lower address is the least significant byte of the word. The sequencer moves bytes between the core's word and the lanes for both reads and writes. The core presents a request while `req_ready` is high. The sequencer then holds off further requests until it has finished. It raises `done` for one cycle once memory has acknowledged the last bus cycle. Each bus cycle on the memory side is held until `mem_ready` is sampled high.

Top module: `bytelane_access`

## Requirements
- R1: While reset is asserted and after reset is released, `req_ready` is 1, and `mem_req` and `done` are 0.
- R2: A byte request at an even address A makes one bus cycle with `mem_addr` = A[19:1] and `mem_be` = 2'b01. For a write, `mem_wdata` = {8'h00, wdata[7:0]}.
- R3: A byte request at an odd address A makes one bus cycle with `mem_addr` = A[19:1] and `mem_be` = 2'b10. For a write, `mem_wdata` = {wdata[7:0], 8'h00}.
- R4: A byte read returns the enabled lane of `mem_rdata` in `rd_data[7:0]`, and `rd_data[15:8]` is 0.
- R5: A word request at an even address makes exactly one bus cycle with `mem_be` = 2'b11. A write drives `mem_wdata` = wdata unchanged. A read returns `rd_data` = `mem_rdata`.
- R6: A word request at an odd address A makes two bus cycles. The first uses `mem_addr` = A[19:1], `mem_be` = 2'b10, and write data {wdata[7:0], 8'h00}. The second uses address A+1 with `mem_be` = 2'b01 and write data {8'h00, wdata[15:8]}. A read returns {second cycle bits 7:0, first cycle bits 15:8}.
- R7: The address A+1 of the second cycle wraps modulo 2^20. An odd word at 20'hFFFFF therefore uses `mem_addr` 0 for its second cycle.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` keep their values into the next cycle.
- R9: `done` rises in the cycle after the edge on which the last bus cycle of a request is acknowledged. It lasts exactly one cycle, and `rd_data` is valid while it is high.
- R10: `req_ready` is low from acceptance until after `done`, so the sequencer takes no new request while busy. While `req_valid` is low, no bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle; request accepted when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, byte reads in bits 7:0 |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 19 | Word (lane pair) address |
| mem_be | output | 2 | Lane enables, bit 0 = low lane |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Read data from memory |
| mem_ready | input | 1 | Memory acknowledges the current bus cycle |

## Verification
Some rules are checked by assertions on every cycle. These are the holding of the bus outputs during wait states, the lane enables of each half of a split word, the one-cycle `done` that follows the last acknowledgement, and the mutual exclusion of `req_ready` and `mem_req`. Other behaviour shows only in the bench scenarios. This covers the address of each bus cycle, the wrap at the top of memory, the byte placement of write data, and the little-endian rebuilding of read data. The bench compares each logged bus cycle and each read result against its own model of the address parity rules, using random addresses and random wait states.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int BUS_W     = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_DONE} seq_state_t;

  // lane enables for one beat
  function automatic logic [NUM_LANES-1:0] beat_lanes(input logic is_word,
                                                      input logic odd,
                                                      input logic second);
    if (is_word && !odd) return 2'b11;
    if (second)          return 2'b01;
    return odd ? 2'b10 : 2'b01;
  endfunction

  // pick one lane of the bus
  function automatic logic [LANE_W-1:0] lane_pick(input logic [BUS_W-1:0] bus,
                                                  input logic hi);
    return hi ? bus[BUS_W-1 -: LANE_W] : bus[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/bl_lane_plan.sv
module bl_lane_plan
  import bl_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_word,
  input  logic                 second,
  input  logic [BUS_W-1:0]     wdata,
  output logic [ADDR_W-2:0]    bus_addr,
  output logic [NUM_LANES-1:0] be,
  output logic [BUS_W-1:0]     bus_wdata,
  output logic                 split
);
  logic              odd;
  logic              full;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANE_W-1:0] one_byte;

  assign odd       = addr[0];
  assign split     = is_word && odd;
  assign full      = is_word && !odd;
  assign beat_addr = second ? addr + ADDR_W'(1) : addr;  // wraps in ADDR_W bits
  assign bus_addr  = beat_addr[ADDR_W-1:1];
  assign be        = beat_lanes(is_word, odd, second);
  assign one_byte  = lane_pick(wdata, second);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign bus_wdata[i*LANE_W +: LANE_W] = !be[i] ? '0 :
                                           (full ? wdata[i*LANE_W +: LANE_W] : one_byte);
  end
endmodule

// File: rtl/bl_read_gather.sv
module bl_read_gather
  import bl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             capture,
  input  logic             is_word,
  input  logic             odd,
  input  logic             second,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [BUS_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      rd_data <= '0;
    end else if (capture) begin
      if (is_word && !odd)
        rd_data <= bus_rdata;
      else if (!is_word)
        rd_data <= {{LANE_W{1'b0}}, lane_pick(bus_rdata, odd)};
      else if (!second)
        rd_data[LANE_W-1:0] <= lane_pick(bus_rdata, 1'b1);
      else
        rd_data[BUS_W-1 -: LANE_W] <= lane_pick(bus_rdata, 1'b0);
    end
  end
endmodule

// File: rtl/bytelane_access.sv
module bytelane_access
  import bl_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_word,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  output logic                 done,
  output logic [BUS_W-1:0]     rd_data,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-2:0]    mem_addr,
  output logic [NUM_LANES-1:0] mem_be,
  output logic [BUS_W-1:0]     mem_wdata,
  input  logic [BUS_W-1:0]     mem_rdata,
  input  logic                 mem_ready
);
  seq_state_t        state, state_nx;
  logic              q_write, q_word;
  logic [ADDR_W-1:0] q_addr;
  logic [BUS_W-1:0]  q_wdata;

  // named events
  logic accept_evt, beat_ack, in_second, split_req, last_beat;

  assign req_ready  = (state == ST_IDLE);
  assign accept_evt = req_valid && req_ready;
  assign mem_req    = (state == ST_FIRST) || (state == ST_SECOND);
  assign in_second  = (state == ST_SECOND);
  assign beat_ack   = mem_req && mem_ready;
  assign last_beat  = beat_ack && (in_second || !split_req);
  assign done       = (state == ST_DONE);
  assign mem_we     = q_write;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept_evt) state_nx = ST_FIRST;
      ST_FIRST:  if (beat_ack)   state_nx = split_req ? ST_SECOND : ST_DONE;
      ST_SECOND: if (beat_ack)   state_nx = ST_DONE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_write <= 1'b0;
      q_word  <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else begin
      state <= state_nx;
      if (accept_evt) begin
        q_write <= req_write;
        q_word  <= req_word;
        q_addr  <= req_addr;
        q_wdata <= req_wdata;
      end
    end
  end

  bl_lane_plan #(.ADDR_W(ADDR_W)) u_plan (
    .addr      (q_addr),
    .is_word   (q_word),
    .second    (in_second),
    .wdata     (q_wdata),
    .bus_addr  (mem_addr),
    .be        (mem_be),
    .bus_wdata (mem_wdata),
    .split     (split_req)
  );

  bl_read_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_evt),
    .capture   (beat_ack && !q_write),
    .is_word   (q_word),
    .odd       (q_addr[0]),
    .second    (in_second),
    .bus_rdata (mem_rdata),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/bl_checks.sv
module bl_checks #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-2:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata,
  input logic              in_second,
  input logic              split_req,
  input logic              last_beat
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !done && req_ready));

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && mem_req));

  assert_split_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && split_req && !in_second) |-> (mem_be == 2'b10));

  assert_split_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && in_second) |-> (mem_be == 2'b01));

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                 && $stable(mem_wdata) && $stable(mem_we)));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_lane_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 2'b00));
endmodule

bind bytelane_access bl_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .in_second (in_second),
  .split_req (split_req),
  .last_beat (last_beat)
);

// File: tb/bytelane_access_test.sv
`timescale 1ns/1ps
module bytelane_access_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_word = 0;
  logic [19:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        req_ready, done, mem_req, mem_we;
  logic [15:0] rd_data, mem_wdata;
  logic [18:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata = 0;
  logic        mem_ready = 0;

  int vectors = 0, fails = 0;
  int nlog = 0;
  logic [18:0] lg_addr [2];
  logic [1:0]  lg_be   [2];
  logic [15:0] lg_wd   [2];
  logic        lg_we   [2];

  always #10 clk = ~clk;  // 50 MHz

  bytelane_access uut (.*);

  function automatic logic [15:0] mem_fn(input logic [18:0] wa);
    return 16'(wa * 19'd40503) ^ 16'h3C5A ^ {wa[18:16], 13'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder with random wait states
  initial begin : responder
    int  wl = 0;
    bit  busy = 0;
    logic [18:0] h_addr; logic [1:0] h_be; logic [15:0] h_wd; logic h_we;
    forever begin
      @(negedge clk);
      mem_ready = 0;
      if (!rst_n || !mem_req) begin busy = 0; continue; end
      if (!busy) begin
        busy = 1; h_addr = mem_addr; h_be = mem_be; h_wd = mem_wdata; h_we = mem_we;
        wl = $urandom_range(0, 2);
      end
      if (wl == 0) begin
        chk({mem_addr, mem_be, mem_wdata, mem_we} == {h_addr, h_be, h_wd, h_we},
            "R8 held during wait", {mem_be, mem_wdata}, {h_be, h_wd});
        if (nlog < 2) begin
          lg_addr[nlog] = mem_addr; lg_be[nlog] = mem_be;
          lg_wd[nlog] = mem_wdata;  lg_we[nlog] = mem_we;
        end
        nlog++;
        mem_rdata = mem_fn(mem_addr);
        mem_ready = 1;
        busy = 0;
      end else wl--;
    end
  end

  task automatic do_req(input bit wr, input bit wd, input logic [19:0] a,
                        input logic [15:0] w);
    int guard = 0;
    int n_exp;
    logic [18:0] ea [2]; logic [1:0] eb [2]; logic [15:0] ew [2];
    logic [19:0] a1;
    logic [15:0] erd;
    string tg;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = wd; req_addr = a; req_wdata = w;
    nlog = 0;
    chk(req_ready == 1, "R10 idle before request", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 0; req_addr = 20'($urandom); req_wdata = 16'($urandom);
    chk(req_ready == 0, "R10 busy blocks requests", 32'(req_ready), 0);
    while (!done && guard < 100) begin @(negedge clk); guard++; end
    chk(done == 1, "R9 done reached", 32'(done), 1);
    a1 = a + 20'd1;
    if (!wd) begin
      n_exp = 1; ea[0] = a[19:1]; eb[0] = a[0] ? 2'b10 : 2'b01;
      ew[0] = a[0] ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
      erd = {8'h00, a[0] ? mem_fn(a[19:1])[15:8] : mem_fn(a[19:1])[7:0]};
      tg = a[0] ? "R3" : "R2";
    end else if (!a[0]) begin
      n_exp = 1; ea[0] = a[19:1]; eb[0] = 2'b11; ew[0] = w;
      erd = mem_fn(a[19:1]); tg = "R5";
    end else begin
      n_exp = 2;
      ea[0] = a[19:1];  eb[0] = 2'b10; ew[0] = {w[7:0], 8'h00};
      ea[1] = a1[19:1]; eb[1] = 2'b01; ew[1] = {8'h00, w[15:8]};
      erd = {mem_fn(a1[19:1])[7:0], mem_fn(a[19:1])[15:8]};
      tg = (a == 20'hFFFFF) ? "R7 R6" : "R6";
    end
    chk(nlog == n_exp, {tg, " bus cycle count"}, 32'(nlog), 32'(n_exp));
    for (int i = 0; i < n_exp && i < nlog; i++) begin
      chk(lg_addr[i] == ea[i], {tg, " mem_addr"}, 32'(lg_addr[i]), 32'(ea[i]));
      chk(lg_be[i] == eb[i], {tg, " mem_be"}, 32'(lg_be[i]), 32'(eb[i]));
      chk(lg_we[i] == wr, {tg, " mem_we"}, 32'(lg_we[i]), 32'(wr));
      if (wr) chk(lg_wd[i] == ew[i], {tg, " mem_wdata"}, 32'(lg_wd[i]), 32'(ew[i]));
    end
    if (!wr) chk(rd_data == erd, wd ? {tg, " read data"} : "R4 byte read data",
                 32'(rd_data), 32'(erd));
    @(negedge clk);
    chk(done == 0, "R9 done one cycle", 32'(done), 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && mem_req == 0 && done == 0, "R1 in reset",
        {req_ready, mem_req, done}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mem_req == 0 && done == 0, "R1 after reset",
        {req_ready, mem_req, done}, 3'b100);
    // R10: no request, no bus activity
    req_addr = 20'h12345; req_word = 1; req_write = 1;
    repeat (5) begin
      @(negedge clk);
      chk(mem_req == 0 && done == 0, "R10 idle without valid", {mem_req, done}, 0);
    end
    // directed corners
    do_req(1, 0, 20'h00010, 16'hAB5C);   // R2
    do_req(1, 0, 20'h00011, 16'hAB5C);   // R3
    do_req(0, 0, 20'h00011, 16'h0);      // R4
    do_req(0, 0, 20'hFFFFE, 16'h0);      // R4
    do_req(1, 1, 20'hFFFFE, 16'h1234);   // R5
    do_req(0, 1, 20'h00200, 16'h0);      // R5
    do_req(1, 1, 20'h00001, 16'hBEEF);   // R6
    do_req(0, 1, 20'h00001, 16'h0);      // R6
    do_req(1, 1, 20'hFFFFF, 16'hC0DE);   // R7
    do_req(0, 1, 20'hFFFFF, 16'h0);      // R7
    for (int k = 0; k < 300; k++)
      do_req(1'($urandom), 1'($urandom), 20'($urandom), 16'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule